// File: doc/BRIEF.md
# Pipelined Radix-4 Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits each and returns the full signed product of `2W` bits. The multiplier operand is recoded into radix-4 digits taken from {-2, -1, 0, +1, +2}. A plain shift-and-add array would need one row per multiplier bit. This block needs only `W/2` rows. Each row adds one selected multiple of the multiplicand to a running sum, and one register stage follows each row. The operands travel down the pipeline next to the running sum, so every row sees the operand bits that belong to its own multiplication.

The data interface is a stream with a valid flag only. A new operand pair may enter on every clock. There is no ready signal and no back-pressure in either direction: an input is taken whenever `in_valid` is high, and a result is presented for exactly one cycle. Cycles where `in_valid` is low travel through as bubbles. `W` must be even.

Top module: `booth_mul_pipe`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the exact signed product of the `in_a`/`in_b` pair that was accepted `W/2` cycles earlier, taken modulo 2^(2W). Both operands are read as two's complement.
- R2: `out_valid` is high in cycle t+`W/2` exactly when `in_valid` was high (outside reset) in cycle t. Idle input cycles come out as cycles with `out_valid` low.
- R3: `rst` is synchronous and active high. It clears every in-flight valid flag, so in the cycle after a reset edge `out_valid` is 0. An input offered in the same cycle as reset is discarded.
- R4: A new pair is accepted on every cycle with no stall. Back-to-back and gapped pairs each yield their own independent product.
- R5: The most negative value times itself gives +2^(2W-2), the one product that needs all 2W bits.
- R6: Digit k is recoded from multiplier bits {2k+1, 2k, 2k-1}, with an implied 0 below bit 0. The mapping is: 000 and 111 select 0; 001 and 010 select +A; 011 selects +2A; 100 selects -2A; 101 and 110 select -A. Every one of these eight triplets yields the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | W | Multiplicand, signed |
| in_b | input | W | Multiplier, signed, Booth-recoded |
| out_valid | output | 1 | Product present this cycle |
| out_product | output | 2W | Signed product |

## Verification
In a single cycle, a fresh pair can enter the first row while the last row retires an older product and every middle row adds its own digit of a different pair. Long runs of back-to-back inputs with random gaps provoke this overlap. Each retired product is judged against a reference queue that holds the pair accepted exactly `W/2` cycles earlier. A second collision is a reset that lands on a full pipeline while `in_valid` is high. It is judged by requiring `out_valid` to be low on the following cycle and by requiring no product from before the reset to appear afterwards.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Recoded digit control: nz = non-zero, dbl = magnitude 2A, neg = negative
  typedef struct packed {
    logic neg;
    logic dbl;
    logic nz;
  } booth_sel_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [2:0] trip_i,
  output booth_sel_t sel_o
);

  // R6: triplet {b[2k+1], b[2k], b[2k-1]} to signed digit
  always_comb begin
    sel_o.nz  = 1'b0;
    sel_o.dbl = 1'b0;
    sel_o.neg = 1'b0;
    case (trip_i)
      3'b001, 3'b010: begin
        sel_o.nz = 1'b1;
      end
      3'b011: begin
        sel_o.nz  = 1'b1;
        sel_o.dbl = 1'b1;
      end
      3'b100: begin
        sel_o.nz  = 1'b1;
        sel_o.dbl = 1'b1;
        sel_o.neg = 1'b1;
      end
      3'b101, 3'b110: begin
        sel_o.nz  = 1'b1;
        sel_o.neg = 1'b1;
      end
      default: begin
        sel_o.nz = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/booth_addend.sv
module booth_addend
  import booth_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 0
) (
  input  logic [W-1:0]   a_i,
  input  booth_sel_t     sel_i,
  output logic [2*W-1:0] addend_o,
  output logic [2*W-1:0] cin_o
);

  localparam int PW = 2 * W;
  localparam int SH = 2 * K;

  logic [PW-1:0] ext;
  logic [PW-1:0] mag;
  logic [PW-1:0] pol;

  // Sign-extend first, then double, so -2 * most-negative still fits
  always_comb begin
    ext = {{W{a_i[W-1]}}, a_i};
    if (!sel_i.nz)
      mag = '0;
    else if (sel_i.dbl)
      mag = ext << 1;
    else
      mag = ext;
    // Negation as one's complement; the +1 rides in cin at the row weight
    pol      = sel_i.neg ? ~mag : mag;
    addend_o = pol << SH;
    cin_o    = '0;
    cin_o[SH] = sel_i.neg;
  end

endmodule

// File: rtl/booth_stage.sv
module booth_stage
  import booth_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_i,
  input  logic [2*W-1:0] sum_i,
  input  logic [W-1:0]   a_i,
  input  logic [2:0]     trip_i,
  output logic           v_o,
  output logic [2*W-1:0] sum_o
);

  localparam int PW = 2 * W;

  booth_sel_t    sel;
  logic [PW-1:0] addend;
  logic [PW-1:0] cin;

  booth_recode u_rec (
    .trip_i (trip_i),
    .sel_o  (sel)
  );

  booth_addend #(.W(W), .K(K)) u_add (
    .a_i      (a_i),
    .sel_i    (sel),
    .addend_o (addend),
    .cin_o    (cin)
  );

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    sum_o <= sum_i + addend + cin;
  end

endmodule

// File: rtl/booth_opnd_reg.sv
module booth_opnd_reg #(
  parameter int AW = 16,
  parameter int BW = 15
) (
  input  logic          clk,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [AW-1:0] a_o,
  output logic [BW-1:0] b_o
);

  always_ff @(posedge clk) begin
    a_o <= a_i;
    b_o <= b_i;
  end

endmodule

// File: rtl/booth_mul_pipe.sv
module booth_mul_pipe #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_product
);

  localparam int N  = W / 2;
  localparam int PW = 2 * W;

  for (genvar k = 0; k < N; k++) begin : g_st
    // Remaining multiplier bits, lowest triplet at [2:0]
    localparam int RW = W + 1 - 2 * k;

    logic          v_in;
    logic [PW-1:0] s_in;
    logic [W-1:0]  a_in;
    logic [RW-1:0] r_in;
    logic          v_out;
    logic [PW-1:0] s_out;

    if (k == 0) begin : g_head
      assign v_in = in_valid;
      assign s_in = '0;
      assign a_in = in_a;
      assign r_in = {in_b, 1'b0};
    end else begin : g_body
      assign v_in = g_st[k-1].v_out;
      assign s_in = g_st[k-1].s_out;
      assign a_in = g_st[k-1].g_fwd.a_nxt;
      assign r_in = g_st[k-1].g_fwd.r_nxt;
    end

    booth_stage #(.W(W), .K(k)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .v_i    (v_in),
      .sum_i  (s_in),
      .a_i    (a_in),
      .trip_i (r_in[2:0]),
      .v_o    (v_out),
      .sum_o  (s_out)
    );

    // Operands move with their partial sum; the last row forwards nothing
    if (k < N - 1) begin : g_fwd
      logic [W-1:0]  a_nxt;
      logic [RW-3:0] r_nxt;

      booth_opnd_reg #(.AW(W), .BW(RW - 2)) u_opnd (
        .clk (clk),
        .a_i (a_in),
        .b_i (r_in[RW-1:2]),
        .a_o (a_nxt),
        .b_o (r_nxt)
      );
    end
  end

  assign out_valid   = g_st[N-1].v_out;
  assign out_product = g_st[N-1].s_out;

endmodule

// File: rtl/booth_mul_pipe_chk.sv
module booth_mul_pipe_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic [2*W-1:0] out_product
);

  localparam int N  = W / 2;
  localparam int PW = 2 * W;

  logic         vq [N];
  logic [W-1:0] aq [N];
  logic [W-1:0] bq [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) vq[i] <= 1'b0;
    end else begin
      vq[0] <= in_valid;
      for (int i = 1; i < N; i++) vq[i] <= vq[i-1];
    end
    aq[0] <= in_a;
    bq[0] <= in_b;
    for (int i = 1; i < N; i++) begin
      aq[i] <= aq[i-1];
      bq[i] <= bq[i-1];
    end
  end

  function automatic logic [PW-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return PW'(ea * eb);
  endfunction

  logic [W-1:0] most_neg;
  assign most_neg = {1'b1, {(W-1){1'b0}}};

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vq[N-1]);

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_product == smul(aq[N-1], bq[N-1]));

  assert_known_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_product));

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_minmin_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && aq[N-1] == most_neg && bq[N-1] == most_neg)
      |-> out_product == (PW'(1) << (PW - 2)));

endmodule

bind booth_mul_pipe booth_mul_pipe_chk #(.W(W)) u_chk (.*);

// File: tb/tb_booth_mul_pipe.sv
`timescale 1ns/1ps

module tb_lane #(
  parameter int W = 8
) (
  input  logic clk,
  output int   n_chk,
  output int   n_err,
  output logic done
);

  localparam int N  = W / 2;
  localparam int PW = 2 * W;

  logic          rst;
  logic          in_valid;
  logic [W-1:0]  in_a;
  logic [W-1:0]  in_b;
  logic          out_valid;
  logic [PW-1:0] out_product;

  booth_mul_pipe #(.W(W)) dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  typedef struct {
    bit            v;
    logic [PW-1:0] p;
    int            tag;
  } ent_t;

  ent_t q[$];
  int   cur_tag;

  logic [W-1:0] mneg;
  logic [W-1:0] mpos;
  assign mneg = {1'b1, {(W-1){1'b0}}};
  assign mpos = ~mneg;

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return PW'(ea * eb);
  endfunction

  // Reference pipeline: one entry per clock, reset empties it (R3)
  always @(posedge clk) begin
    ent_t e;
    if (rst) foreach (q[i]) q[i].v = 1'b0;
    e.v   = in_valid && !rst;
    e.p   = ref_mul(in_a, in_b);
    e.tag = cur_tag;
    q.push_back(e);
    if (q.size() > N) void'(q.pop_front());
  end

  // Every cycle: R2 valid timing, and the product under the entry's tag
  always @(negedge clk) begin
    if (q.size() == N) begin
      n_chk++;
      if (out_valid !== q[0].v) begin
        n_err++;
        $display("FAIL W=%0d R2 out_valid actual=%b expected=%b", W, out_valid, q[0].v);
      end
      if (q[0].v) begin
        n_chk++;
        if (out_product !== q[0].p) begin
          n_err++;
          $display("FAIL W=%0d R%0d out_product actual=%h expected=%h",
                   W, q[0].tag, out_product, q[0].p);
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input int tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
    cur_tag  = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_a     = W'($urandom);
    in_b     = W'($urandom);
  endtask

  task automatic check_low(input string what);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL W=%0d R3 %s out_valid actual=%b expected=0", W, what, out_valid);
    end
  endtask

  initial begin
    logic [15:0] pats [10];
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    rst   = 1'b1;
    in_valid = 1'b0;
    in_a  = '0;
    in_b  = '0;
    cur_tag = 1;
    pats = '{16'h5555, 16'hAAAA, 16'h3333, 16'hCCCC, 16'h6666,
             16'h9999, 16'hFFFF, 16'h0F0F, 16'h7777, 16'h8888};

    repeat (3) @(negedge clk);
    check_low("reset state");          // R3
    rst = 1'b0;

    // R5 and R1 corner pairs, back to back
    send(mneg, mneg, 5);
    send(mneg, mpos, 1);
    send(mpos, mneg, 1);
    send(mpos, mpos, 1);
    send('0, mneg, 1);
    send('1, '1, 1);
    send(W'(1), '1, 1);
    send(mneg, W'(1), 1);
    send(mneg, '1, 1);

    // R6: every triplet code appears across these multiplier patterns
    foreach (pats[i]) begin
      send(W'(7), pats[i][W-1:0], 6);
      send(-W'(3), pats[i][W-1:0], 6);
      send(mneg, pats[i][W-1:0], 6);
    end

    // R2: gaps become bubbles
    send(W'(5), W'(9), 1);
    idle();
    send(-W'(5), W'(9), 1);
    idle();
    idle();

    // R4: random back-to-back traffic with occasional gaps
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) != 0) send(W'($urandom), W'($urandom), 4);
      else idle();
    end

    // R3: reset while the pipeline is full and input is still offered
    for (int i = 0; i < N; i++) send(W'($urandom), W'($urandom), 3);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check_low("after mid-stream reset");
    rst = 1'b0;
    in_valid = 1'b0;

    send(mneg, mneg, 5);
    repeat (N + 3) idle();
    done = 1'b1;
  end

endmodule

module tb_booth_mul_pipe;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int   c8, e8, c16, e16;
  logic d8, d16;

  tb_lane #(.W(8))  u_w8  (.clk(clk), .n_chk(c8),  .n_err(e8),  .done(d8));
  tb_lane #(.W(16)) u_w16 (.clk(clk), .n_chk(c16), .n_err(e16), .done(d16));

  initial begin
    int cyc;
    int wd;
    cyc = 0;
    wd  = 0;
    while (!(d8 === 1'b1 && d16 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d8 === 1'b1 && d16 === 1'b1)) begin
      wd = 1;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", e8 + e16 + wd, c8 + c16 + wd);
    $finish;
  end

endmodule